// File: doc/BRIEF.md
# Two-Wire Wiper and Scratch Register Slave

This block is a slave on a two-wire serial bus made of a clock line and an open-drain data line. It holds two byte-wide registers. One is a free scratch byte. The other is a wiper code that picks one of 256 taps on a resistive divider, and it is exported as an 8-bit output for the analog array next to the block. Both bus lines are brought into the fast system clock through synchronizer flops. All bus events (clock edges, start, stop) are found by comparing successive synchronized samples.

A master addresses the slave with a control byte. That byte is four fixed identifier bits, then the three address strap pins, then a direction bit. A write continues with a command byte and one or two data bytes. A read returns the scratch byte followed by the wiper code. The slave pulls the data line low through `sda_oe` and never drives it high.

Top module: `twowire_pot_slave`

## Requirements
- R1: After reset, the wiper code and the scratch byte are both 00h and `sda_oe` is 0 (data line released).
- R2: A control byte is acknowledged only when its upper nibble is 0101b and its bits 3..1 equal the current level of `addr_pins`, which is compared live at the moment the byte completes. Any other control byte is not acknowledged, and the slave ignores the bus until the next start.
- R3: Command A9h writes the following data byte into the scratch byte. An optional second data byte in the same transfer is written into the wiper code.
- R4: Command AAh writes the following data byte into the wiper code only; the scratch byte keeps its value. The wiper output changes only while SCL is low.
- R5: Command AFh writes the following data byte into both registers.
- R6: Every accepted byte is acknowledged by holding `sda_oe` at 1 for the whole high phase of the ninth clock. `sda_oe` changes only while SCL is low.
- R7: A read (direction bit 1, bit 0 of the control byte) returns the scratch byte and then the wiper code, MSB first. After the master answers a byte with NACK, or after the wiper byte, the slave keeps the data line released, so any further bytes clocked out read FFh.
- R8: A command byte other than A9h, AAh or AFh is not acknowledged, and neither register changes before the next start.
- R9: A stop or a start that arrives partway through a byte discards the partial byte. A start at any point returns the slave to waiting for a control byte.
- R10: Data bytes beyond the last one a command defines are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Data line level as seen on the wired bus |
| addr_pins | input | 3 | Address straps compared with control byte bits 3..1 |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| wiper_code | output | 8 | Current tap selection for the divider |

## Verification
The bench goes after the optional second byte of A9h. A slave that drops it leaves the wiper stale, and one that accepts it after AAh or AFh corrupts the wiper. It changes the strap pins between transfers to catch a slave that latched its address at reset, since such a slave keeps answering to the old address. Partial bytes followed by a stop or a repeated start expose a slave that commits half a byte or stays out of step with the bit count. Reads that go past the defined bytes, or that the master ends with NACK, catch a slave that keeps driving the data line and would block the master's stop.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OPC_SCRATCH = 8'hA9;
    localparam byte_t OPC_WIPER   = 8'hAA;
    localparam byte_t OPC_BOTH    = 8'hAF;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX,
        LK_RX_ACK,
        LK_TX,
        LK_TX_ACK
    } link_st_e;

    typedef enum logic [2:0] {
        PH_CTRL,
        PH_CMD,
        PH_DATA0,
        PH_DATA1,
        PH_RD0,
        PH_RD1,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        OPK_NONE,
        OPK_SCRATCH,
        OPK_WIPER,
        OPK_BOTH
    } op_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic  we_scratch;
        logic  we_wiper;
        byte_t data;
    } reg_wr_t;

    function automatic op_e decode_op(byte_t b);
        case (b)
            OPC_SCRATCH: return OPK_SCRATCH;
            OPC_WIPER:   return OPK_WIPER;
            OPC_BOTH:    return OPK_BOTH;
            default:     return OPK_NONE;
        endcase
    endfunction

    function automatic logic ctrl_hit(byte_t b, logic [2:0] pins, logic [3:0] id);
        return (b[7:4] == id) && (b[3:1] == pins);
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-1:0], d};
    end

    assign q      = pipe[STAGES-1];
    assign q_prev = pipe[STAGES];
endmodule

// File: rtl/tw_regs.sv
module tw_regs
    import tw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reg_wr_t wr,
    output byte_t   scratch,
    output byte_t   wiper
);
    always_ff @(posedge clk) begin
        if (rst) begin
            scratch <= '0;
            wiper   <= '0;
        end else begin
            if (wr.we_scratch) scratch <= wr.data;
            if (wr.we_wiper)   wiper   <= wr.data;
        end
    end
endmodule

// File: rtl/tw_link_fsm.sv
module tw_link_fsm
    import tw_pkg::*;
#(
    parameter logic [3:0] DEV_ID = 4'b0101
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [2:0] pins,
    input  byte_t      scratch,
    input  byte_t      wiper,
    output reg_wr_t    wr,
    output logic       sda_oe
);
    link_st_e          st;
    phase_e            ph;
    op_e               op;
    logic [CNT_W-1:0]  cnt;
    byte_t             sh;
    logic              oe_q;
    logic              mack;

    logic   byte_done;
    logic   rx_ack;
    phase_e rx_next;
    op_e    op_dec;

    assign byte_done = (st == LK_RX) && ev.scl_fall && (cnt == CNT_W'(BYTE_W))
                       && !ev.start && !ev.stop;

    always_comb begin
        rx_ack  = 1'b0;
        rx_next = ph;
        op_dec  = decode_op(sh);
        wr      = '0;
        wr.data = sh;
        case (ph)
            PH_CTRL: begin
                if (ctrl_hit(sh, pins, DEV_ID)) begin
                    rx_ack  = 1'b1;
                    rx_next = sh[0] ? PH_RD0 : PH_CMD;
                end
            end
            PH_CMD: begin
                if (op_dec != OPK_NONE) begin
                    rx_ack  = 1'b1;
                    rx_next = PH_DATA0;
                end
            end
            PH_DATA0: begin
                rx_ack        = 1'b1;
                rx_next       = (op == OPK_SCRATCH) ? PH_DATA1 : PH_DONE;
                wr.we_scratch = byte_done && (op != OPK_WIPER);
                wr.we_wiper   = byte_done && (op != OPK_SCRATCH);
            end
            PH_DATA1: begin
                rx_ack      = 1'b1;
                rx_next     = PH_DONE;
                wr.we_wiper = byte_done;
            end
            default: begin
                rx_ack = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LK_IDLE;
            ph   <= PH_CTRL;
            op   <= OPK_NONE;
            cnt  <= '0;
            sh   <= '0;
            oe_q <= 1'b0;
            mack <= 1'b0;
        end else if (ev.start) begin
            st   <= LK_RX;
            ph   <= PH_CTRL;
            cnt  <= '0;
            oe_q <= 1'b0;
        end else if (ev.stop) begin
            st   <= LK_IDLE;
            cnt  <= '0;
            oe_q <= 1'b0;
        end else begin
            case (st)
                LK_RX: begin
                    if (ev.scl_rise && (cnt < CNT_W'(BYTE_W))) begin
                        sh  <= {sh[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (rx_ack) begin
                            oe_q <= 1'b1;
                            st   <= LK_RX_ACK;
                            ph   <= rx_next;
                            if (ph == PH_CMD) op <= op_dec;
                        end else begin
                            st <= LK_IDLE;
                        end
                    end
                end
                LK_RX_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (ph == PH_RD0) begin
                            st   <= LK_TX;
                            sh   <= scratch;
                            oe_q <= ~scratch[BYTE_W-1];
                        end else begin
                            st   <= LK_RX;
                            oe_q <= 1'b0;
                        end
                    end
                end
                LK_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            oe_q <= 1'b0;
                            st   <= LK_TX_ACK;
                        end else begin
                            sh   <= {sh[BYTE_W-2:0], 1'b0};
                            oe_q <= ~sh[BYTE_W-2];
                            cnt  <= cnt + 1'b1;
                        end
                    end
                end
                LK_TX_ACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        cnt <= '0;
                        if (mack && (ph == PH_RD0)) begin
                            ph   <= PH_RD1;
                            st   <= LK_TX;
                            sh   <= wiper;
                            oe_q <= ~wiper[BYTE_W-1];
                        end else begin
                            st <= LK_IDLE;
                        end
                    end
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign sda_oe = oe_q;
endmodule

// File: rtl/twowire_pot_slave.sv
module twowire_pot_slave
    import tw_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ID      = 4'b0101
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] addr_pins,
    output logic       sda_oe,
    output logic [7:0] wiper_code
);
    localparam int N_LINES = 2;
    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [N_LINES-1:0] raw, cur, prv;
    bus_ev_t ev;
    reg_wr_t wr;
    byte_t   scratch, wiper;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .d      (raw[g]),
            .q      (cur[g]),
            .q_prev (prv[g])
        );
    end

    always_comb begin
        ev.scl_rise = cur[IDX_SCL] & ~prv[IDX_SCL];
        ev.scl_fall = ~cur[IDX_SCL] & prv[IDX_SCL];
        ev.start    = cur[IDX_SCL] & prv[IDX_SCL] & prv[IDX_SDA] & ~cur[IDX_SDA];
        ev.stop     = cur[IDX_SCL] & prv[IDX_SCL] & ~prv[IDX_SDA] & cur[IDX_SDA];
        ev.sda      = cur[IDX_SDA];
    end

    tw_link_fsm #(.DEV_ID(DEV_ID)) u_link (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .pins    (addr_pins),
        .scratch (scratch),
        .wiper   (wiper),
        .wr      (wr),
        .sda_oe  (sda_oe)
    );

    tw_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .scratch (scratch),
        .wiper   (wiper)
    );

    assign wiper_code = wiper;
endmodule

// File: rtl/twowire_pot_slave_chk.sv
module twowire_pot_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       sda_oe,
    input logic [7:0] wiper_code
);
    // R1: wiper cleared by reset
    a_r1_wiper_clear_after_reset: assert property (@(posedge clk)
        rst |=> (wiper_code == 8'h00));

    // R1: data line released by reset
    a_r1_sda_released_after_reset: assert property (@(posedge clk)
        rst |=> !sda_oe);

    // R6: pull-down only moves while SCL is low
    a_r6_sda_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_in);

    // R4: wiper only moves while SCL is low
    a_r4_wiper_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(wiper_code) |-> !scl_in);
endmodule

bind twowire_pot_slave twowire_pot_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_in     (scl_in),
    .sda_oe     (sda_oe),
    .wiper_code (wiper_code)
);

// File: tb/twowire_pot_slave_bench.sv
module twowire_pot_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 190000;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       scl   = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] pins  = 3'b101;
    logic       sda_oe;
    logic [7:0] wiper;
    logic       sda_line;
    bit         finished = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    twowire_pot_slave u_twowire_pot_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl),
        .sda_in     (sda_line),
        .addr_pins  (pins),
        .sda_oe     (sda_oe),
        .wiper_code (wiper)
    );

    typedef struct {
        int    val;
        string req;
    } item_t;

    item_t exp_q[$];
    int    obs_q[$];
    int    n_chk = 0;
    int    n_err = 0;

    task automatic pause(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_v(int v, string r);
        exp_q.push_back('{val: v, req: r});
    endtask

    task automatic observe(int v);
        obs_q.push_back(v);
    endtask

    task automatic check_port(int actual, int expected, string r);
        expect_v(expected, r);
        observe(actual);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                int    a;
                item_t e;
                a = obs_q.pop_front();
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL scoreboard: actual 0x%0h expected nothing", a);
                end else begin
                    e = exp_q.pop_front();
                    if (a != e.val) begin
                        n_err++;
                        $display("FAIL %s: actual 0x%0h expected 0x%0h", e.req, a, e.val);
                    end
                end
            end
        end
    end

    function automatic logic [7:0] ctl(logic rw);
        return {4'b0101, pins, rw};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; pause(HALF);
        scl   = 1'b1; pause(HALF);
        sda_m = 1'b0; pause(HALF);
        scl   = 1'b0; pause(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; pause(HALF);
        scl   = 1'b1; pause(HALF);
        sda_m = 1'b1; pause(HALF);
    endtask

    task automatic clock_bit(logic b);
        sda_m = b; pause(HALF);
        scl   = 1'b1; pause(HALF);
        scl   = 1'b0; pause(2);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) clock_bit(b[7-i]);
    endtask

    task automatic send_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        sda_m = 1'b1; pause(HALF);
        scl   = 1'b1; pause(1);
        acked = ~sda_line;
        pause(HALF - 2);
        acked = acked & ~sda_line;
        pause(1);
        scl = 1'b0; pause(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; pause(HALF);
            scl   = 1'b1; pause(HALF/2);
            b[i]  = sda_line;
            pause(HALF/2);
            scl   = 1'b0; pause(2);
        end
        sda_m = ~give_ack; pause(HALF);
        scl   = 1'b1; pause(HALF);
        scl   = 1'b0; pause(2);
        sda_m = 1'b1;
    endtask

    // driver: pushes expected acks, then drives the transfer
    task automatic write_seq(logic [31:0] seq, int n, logic [3:0] ack_mask, string r);
        logic a;
        bus_start();
        for (int k = 0; k < n; k++) begin
            expect_v(int'(ack_mask[3-k]), {r, " ack (R6)"});
            send_byte(seq[31-8*k -: 8], a);
            observe(int'(a));
        end
        bus_stop();
    endtask

    task automatic read_seq(int nbytes, logic [7:0] e0, logic [7:0] e1, string r);
        logic       a;
        logic [7:0] d;
        bus_start();
        expect_v(1, {r, " read control ack"});
        send_byte(ctl(1'b1), a);
        observe(int'(a));
        expect_v(int'(e0), {r, " first read byte"});
        recv_byte(d, nbytes > 1);
        observe(int'(d));
        if (nbytes > 1) begin
            expect_v(int'(e1), {r, " second read byte"});
            recv_byte(d, 1'b0);
            observe(int'(d));
        end
        bus_stop();
    endtask

    initial begin
        pause(WATCHDOG);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] d;

        pause(5);
        rst = 1'b0;
        pause(3);

        // R1: reset state
        check_port(int'(wiper), 0, "R1 wiper after reset");
        check_port(int'(sda_oe), 0, "R1 line released after reset");
        read_seq(2, 8'h00, 8'h00, "R1");

        // R3: scratch write with no second byte
        write_seq({ctl(1'b0), 8'hA9, 8'h3C, 8'h00}, 3, 4'b1110, "R3");
        check_port(int'(wiper), 8'h00, "R3 wiper untouched without second byte");
        read_seq(2, 8'h3C, 8'h00, "R3");

        // R3: scratch plus optional wiper byte
        write_seq({ctl(1'b0), 8'hA9, 8'h11, 8'h77}, 4, 4'b1111, "R3");
        check_port(int'(wiper), 8'h77, "R3 second byte to wiper");
        read_seq(2, 8'h11, 8'h77, "R3 R7");

        // R4: wiper only
        write_seq({ctl(1'b0), 8'hAA, 8'hC4, 8'h00}, 3, 4'b1110, "R4");
        check_port(int'(wiper), 8'hC4, "R4 wiper written");
        read_seq(2, 8'h11, 8'hC4, "R4 scratch kept");

        // R5: both registers
        write_seq({ctl(1'b0), 8'hAF, 8'h5E, 8'h00}, 3, 4'b1110, "R5");
        check_port(int'(wiper), 8'h5E, "R5 wiper");
        read_seq(2, 8'h5E, 8'h5E, "R5");

        // R10: extra bytes NACKed and ignored
        write_seq({ctl(1'b0), 8'hAF, 8'h21, 8'h99}, 4, 4'b1110, "R10");
        check_port(int'(wiper), 8'h21, "R10 wiper after extra byte");
        read_seq(2, 8'h21, 8'h21, "R10");
        write_seq({ctl(1'b0), 8'hAA, 8'h34, 8'h56}, 4, 4'b1110, "R10");
        check_port(int'(wiper), 8'h34, "R10 wiper ignores extra byte");

        // R2: address mismatch, then live pin change
        write_seq({4'b0101, 3'b100, 1'b0, 8'hAA, 8'h00, 8'h00}, 3, 4'b0000, "R2 mismatch");
        check_port(int'(wiper), 8'h34, "R2 wiper after mismatch");
        pins = 3'b100;
        pause(4);
        write_seq({ctl(1'b0), 8'hAA, 8'h4B, 8'h00}, 3, 4'b1110, "R2 live pins");
        check_port(int'(wiper), 8'h4B, "R2 wiper via new address");
        write_seq({4'b0110, pins, 1'b0, 8'hAA, 8'h00, 8'h00}, 3, 4'b0000, "R2 wrong identifier");
        check_port(int'(wiper), 8'h4B, "R2 wiper after wrong identifier");

        // R8: unknown command
        write_seq({ctl(1'b0), 8'hA5, 8'h00, 8'h00}, 3, 4'b1000, "R8");
        check_port(int'(wiper), 8'h4B, "R8 wiper unchanged");
        read_seq(2, 8'h21, 8'h4B, "R8 scratch unchanged");

        // R7: NACK on first byte releases the line
        bus_start();
        expect_v(1, "R7 control ack");
        send_byte(ctl(1'b1), a);
        observe(int'(a));
        expect_v(8'h21, "R7 scratch byte");
        recv_byte(d, 1'b0);
        observe(int'(d));
        expect_v(8'hFF, "R7 released after NACK");
        recv_byte(d, 1'b0);
        observe(int'(d));
        bus_stop();

        // R7: bytes past the wiper read as released
        bus_start();
        expect_v(1, "R7 control ack");
        send_byte(ctl(1'b1), a);
        observe(int'(a));
        expect_v(8'h21, "R7 scratch first");
        recv_byte(d, 1'b1);
        observe(int'(d));
        expect_v(8'h4B, "R7 wiper second");
        recv_byte(d, 1'b1);
        observe(int'(d));
        expect_v(8'hFF, "R7 released past wiper");
        recv_byte(d, 1'b0);
        observe(int'(d));
        bus_stop();
        check_port(int'(sda_oe), 0, "R7 line released after read");

        // R9: stop partway through a data byte
        bus_start();
        expect_v(1, "R9 control ack");
        send_byte(ctl(1'b0), a);
        observe(int'(a));
        expect_v(1, "R9 command ack");
        send_byte(8'hAA, a);
        observe(int'(a));
        send_bits(8'hE0, 4);
        bus_stop();
        check_port(int'(wiper), 8'h4B, "R9 partial byte before stop dropped");

        // R9: repeated start partway through a data byte
        bus_start();
        expect_v(1, "R9 control ack");
        send_byte(ctl(1'b0), a);
        observe(int'(a));
        expect_v(1, "R9 command ack");
        send_byte(8'hAA, a);
        observe(int'(a));
        send_bits(8'h80, 3);
        bus_start();
        expect_v(1, "R9 control ack after repeated start");
        send_byte(ctl(1'b1), a);
        observe(int'(a));
        expect_v(8'h21, "R9 read after repeated start");
        recv_byte(d, 1'b0);
        observe(int'(d));
        bus_stop();
        check_port(int'(wiper), 8'h4B, "R9 partial byte before start dropped");

        pause(20);
        while (exp_q.size() > 0) begin
            item_t e;
            e = exp_q.pop_front();
            n_chk++;
            n_err++;
            $display("FAIL %s: actual none expected 0x%0h", e.req, e.val);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule